// File: doc/BRIEF.md
# Interrupt Enable and Mask Control Unit

This block carries out the machine-control opcodes of a small 8-bit processor: no-operation, halt, interrupt disable, interrupt enable, mask write and mask read. It owns the interrupt-enable flag, a three-bit mask over three maskable interrupt lines, a serial output bit and the halted state. It reports how many clock states each accepted instruction takes. It also presents the one interrupt that should be serviced now, chosen from the maskable lines and one non-maskable trap line.

The core's decoder offers one opcode byte per cycle with a valid strobe. The accumulator value goes with a mask-write opcode. The interrupt lines, the trap line, the serial input bit and an acknowledge from the sequencer arrive as plain level inputs. Instruction decode outside this group, and the datapath, belong elsewhere.

Top module: `mctl_irq_unit`

## Requirements
- R1: After a synchronous active-low reset: enable flag 0, mask 3'b111, serial output 0, halted 0, state count 0, status byte 0x00, no interrupt forwarded.
- R2: An accepted opcode loads the state count on the next edge. 0x00, 0xF3, 0xFB, 0x30 and 0x20 load 4. 0x76 loads 5. Any other byte loads 0 and changes no other state.
- R3: 0x00 (no-op) changes none of enable flag, mask, serial output or status byte.
- R4: 0xFB sets the enable flag and 0xF3 clears it. The flag is seen in bit 3 of the status byte.
- R5: An acknowledge clears the enable flag on the next edge, even when 0xFB is accepted in the same cycle.
- R6: 0x30 copies accumulator bits 2:0 into the mask only when accumulator bit 3 is 1. Otherwise the mask is kept.
- R7: 0x30 copies accumulator bit 7 to the serial output only when accumulator bit 6 is 1. Otherwise the serial output is kept.
- R8: 0x20 loads the status byte on the next edge. Bit 7 is the serial input, bits 6:4 are interrupt lines 2:0, bit 3 is the enable flag and bits 2:0 are the mask. The status byte holds its value otherwise.
- R9: A maskable line i is forwarded when it is high, the enable flag is 1 and mask bit i is 0. The forwarded selection is one-hot: bit i for line i, and the highest-numbered forwarded line wins.
- R10: The trap input is always forwarded as selection bit 3, over every maskable line, whatever the enable flag and mask hold.
- R11: An accepted 0x76 sets halted. While halted, opcodes are ignored. Halted clears on the edge after any interrupt or trap is forwarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_valid | input | 1 | Opcode byte valid this cycle |
| op_code | input | 8 | Opcode byte |
| acc_in | input | 8 | Accumulator value used by mask write |
| ser_in | input | 1 | Serial input bit, reported by mask read |
| irq_req | input | 3 | Maskable interrupt lines, level |
| trap_req | input | 1 | Non-maskable trap line, level |
| intr_ack | input | 1 | Interrupt acknowledge from sequencer |
| t_states | output | 4 | State count of the last accepted opcode |
| rim_status | output | 8 | Status byte captured by mask read |
| ser_out | output | 1 | Serial output bit |
| halted | output | 1 | Processor halted |
| int_req | output | 1 | An interrupt or trap is forwarded |
| int_sel | output | 4 | One-hot forwarded source, bit 3 = trap |

## Verification
A wrong enable flag or mask bit shows at once on the interrupt outputs in the cycle after the update, as long as a line is raised. With the lines quiet, it shows one edge after a mask read through the status byte. A halted state that sticks or drops early shows as a changed or unchanged state count after the next opcode. A lost serial-output write shows on the pin on the next edge. The stimulus therefore reads back the status byte after every state-changing opcode and raises interrupt lines under each enable and mask setting.

// File: rtl/mctl_pkg.sv
// Package: shared opcode values, opcode classes and mask-write field positions
// for the machine-control unit. Assumes an 8-bit accumulator.
package mctl_pkg;

    localparam logic [7:0] OPC_NOP = 8'h00;
    localparam logic [7:0] OPC_HLT = 8'h76;
    localparam logic [7:0] OPC_DI  = 8'hF3;
    localparam logic [7:0] OPC_EI  = 8'hFB;
    localparam logic [7:0] OPC_SIM = 8'h30;
    localparam logic [7:0] OPC_RIM = 8'h20;

    // mask-write field positions inside the accumulator
    localparam int MW_MASK_EN_BIT = 3;
    localparam int MW_SER_EN_BIT  = 6;
    localparam int MW_SER_VAL_BIT = 7;

    // state counts
    localparam int TS_SHORT = 4;
    localparam int TS_HALT  = 5;

    typedef enum logic [2:0] {
        K_NOP,
        K_HLT,
        K_DI,
        K_EI,
        K_MSET,
        K_MGET,
        K_BAD
    } op_kind_e;

    // classify one opcode byte
    function automatic op_kind_e classify(input logic [7:0] code);
        case (code)
            OPC_NOP: classify = K_NOP;
            OPC_HLT: classify = K_HLT;
            OPC_DI:  classify = K_DI;
            OPC_EI:  classify = K_EI;
            OPC_SIM: classify = K_MSET;
            OPC_RIM: classify = K_MGET;
            default: classify = K_BAD;
        endcase
    endfunction

endpackage

// File: rtl/mctl_decode.sv
// Module: classifies the incoming opcode byte, decides acceptance (nothing is
// accepted while halted) and registers the state count of the accepted opcode.
// Assumes one opcode per cycle when op_valid is high.
module mctl_decode
    import mctl_pkg::*;
#(
    parameter int TS_W = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            op_valid,
    input  logic [7:0]      op_code,
    input  logic            halted,
    output op_kind_e        kind,
    output logic            accept,
    output logic [TS_W-1:0] t_states
);

    // purpose: decode class of the current byte
    always_comb begin
        kind = classify(op_code);
    end

    // purpose: an opcode is taken only when valid and the core runs
    always_comb begin
        accept = op_valid && !halted;
    end

    // purpose: hold the state count of the last accepted opcode
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            t_states <= '0;
        end else if (accept) begin
            case (kind)
                K_HLT:   t_states <= TS_W'(TS_HALT);
                K_BAD:   t_states <= '0;
                default: t_states <= TS_W'(TS_SHORT);
            endcase
        end
    end

    // R2: a halt opcode taken yields five states
    p_halt_five_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && !halted && op_code == OPC_HLT) |=> (t_states == TS_W'(TS_HALT)));

    // R11: no opcode is taken while halted, so the count holds
    p_count_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> $stable(t_states));

endmodule

// File: rtl/mctl_state.sv
// Module: architectural state of the control unit: enable flag, mask,
// serial output, halted flag and the status byte built by mask read.
// Assumes the forwarded-interrupt indication comes from the gate in the
// same cycle; acknowledge has priority over an enable opcode.
module mctl_state
    import mctl_pkg::*;
#(
    parameter int N_IRQ = 3,
    localparam int ST_W = 2 * N_IRQ + 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             accept,
    input  op_kind_e         kind,
    input  logic [7:0]       acc_in,
    input  logic             ser_in,
    input  logic [N_IRQ-1:0] irq_req,
    input  logic             intr_ack,
    input  logic             fwd_any,
    output logic             ie,
    output logic [N_IRQ-1:0] mask,
    output logic             ser_out,
    output logic             halted,
    output logic [ST_W-1:0]  status
);

    logic do_mset;
    logic do_mget;

    // purpose: one-cycle strobes for the mask opcodes
    always_comb begin
        do_mset = accept && (kind == K_MSET);
        do_mget = accept && (kind == K_MGET);
    end

    // purpose: enable flag, cleared by reset and by acknowledge
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ie <= 1'b0;
        end else if (intr_ack) begin
            ie <= 1'b0;
        end else if (accept && kind == K_EI) begin
            ie <= 1'b1;
        end else if (accept && kind == K_DI) begin
            ie <= 1'b0;
        end
    end

    // purpose: mask bits, written only when the mask-enable field is set
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask <= '1;
        end else if (do_mset && acc_in[MW_MASK_EN_BIT]) begin
            mask <= acc_in[N_IRQ-1:0];
        end
    end

    // purpose: serial output, written only when the serial-enable field is set
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ser_out <= 1'b0;
        end else if (do_mset && acc_in[MW_SER_EN_BIT]) begin
            ser_out <= acc_in[MW_SER_VAL_BIT];
        end
    end

    // purpose: halted flag, set by halt opcode, cleared by any forwarded source
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            halted <= 1'b0;
        end else if (halted) begin
            if (fwd_any) begin
                halted <= 1'b0;
            end
        end else if (accept && kind == K_HLT) begin
            halted <= 1'b1;
        end
    end

    // purpose: status byte captured by mask read
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status <= '0;
        end else if (do_mget) begin
            status <= {ser_in, irq_req, ie, mask};
        end
    end

    // R5: acknowledge always leaves the flag clear
    p_ack_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
        intr_ack |=> !ie);

    // R6: a mask write without the enable field keeps the mask
    p_mask_keep_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (do_mset && !acc_in[MW_MASK_EN_BIT]) |=> $stable(mask));

    // R7: a mask write without the serial-enable field keeps the output
    p_ser_keep_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (do_mset && !acc_in[MW_SER_EN_BIT]) |=> $stable(ser_out));

    // R11: halted stays while nothing is forwarded
    p_halt_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (halted && !fwd_any) |=> halted);

    // R3: a no-op leaves the enable flag and mask alone
    p_nop_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && kind == K_NOP && !intr_ack) |=> ($stable(ie) && $stable(mask)));

endmodule

// File: rtl/mctl_gate.sv
// Module: combinational interrupt gate. Qualifies maskable lines by enable
// flag and mask, picks the highest-numbered live line, and lets the trap line
// through unconditionally with top priority. Assumes level inputs.
module mctl_gate #(
    parameter int N_IRQ = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ie,
    input  logic [N_IRQ-1:0] mask,
    input  logic [N_IRQ-1:0] irq_req,
    input  logic             trap_req,
    output logic             int_req,
    output logic [N_IRQ:0]   int_sel
);

    logic [N_IRQ-1:0] live;

    // purpose: lines allowed through by enable flag and mask
    always_comb begin
        live = irq_req & ~mask & {N_IRQ{ie}};
    end

    // purpose: one-hot pick, trap first, then highest-numbered live line
    always_comb begin
        int_sel = '0;
        if (trap_req) begin
            int_sel[N_IRQ] = 1'b1;
        end else begin
            for (int i = 0; i < N_IRQ; i++) begin
                if (live[i]) begin
                    int_sel = '0;
                    int_sel[i] = 1'b1;
                end
            end
        end
    end

    // purpose: any source forwarded
    always_comb begin
        int_req = trap_req || (|live);
    end

    // R9: at most one source is selected
    p_sel_onehot_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(int_sel));

    // R9: with the flag clear only the trap can be selected
    p_flag_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!ie && !trap_req) |-> (int_sel == '0));

    // R10: trap selects its own bit whatever the flag and mask hold
    p_trap_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
        trap_req |-> (int_req && int_sel[N_IRQ]));

endmodule

// File: rtl/mctl_irq_unit.sv
// Module: top of the machine-control unit. Ties decode, state and gate
// together. Assumes the opcode byte arrives pre-fetched with a valid strobe
// and that the acknowledge is a single-cycle pulse from the sequencer.
module mctl_irq_unit
    import mctl_pkg::*;
#(
    parameter int N_IRQ = 3,
    parameter int TS_W  = 4,
    localparam int ST_W = 2 * N_IRQ + 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             op_valid,
    input  logic [7:0]       op_code,
    input  logic [7:0]       acc_in,
    input  logic             ser_in,
    input  logic [N_IRQ-1:0] irq_req,
    input  logic             trap_req,
    input  logic             intr_ack,
    output logic [TS_W-1:0]  t_states,
    output logic [ST_W-1:0]  rim_status,
    output logic             ser_out,
    output logic             halted,
    output logic             int_req,
    output logic [N_IRQ:0]   int_sel
);

    op_kind_e         kind;
    logic             accept;
    logic             ie;
    logic [N_IRQ-1:0] mask;

    mctl_decode #(
        .TS_W (TS_W)
    ) u_decode (
        .clk      (clk),
        .rst_n    (rst_n),
        .op_valid (op_valid),
        .op_code  (op_code),
        .halted   (halted),
        .kind     (kind),
        .accept   (accept),
        .t_states (t_states)
    );

    mctl_state #(
        .N_IRQ (N_IRQ)
    ) u_state (
        .clk      (clk),
        .rst_n    (rst_n),
        .accept   (accept),
        .kind     (kind),
        .acc_in   (acc_in),
        .ser_in   (ser_in),
        .irq_req  (irq_req),
        .intr_ack (intr_ack),
        .fwd_any  (int_req),
        .ie       (ie),
        .mask     (mask),
        .ser_out  (ser_out),
        .halted   (halted),
        .status   (rim_status)
    );

    mctl_gate #(
        .N_IRQ (N_IRQ)
    ) u_gate (
        .clk      (clk),
        .rst_n    (rst_n),
        .ie       (ie),
        .mask     (mask),
        .irq_req  (irq_req),
        .trap_req (trap_req),
        .int_req  (int_req),
        .int_sel  (int_sel)
    );

    // R4: an enable opcode without acknowledge leaves the flag set
    p_enable_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && !halted && op_code == OPC_EI && !intr_ack) |=> u_state.ie);

    // R8: a mask read captures the serial input into the top status bit
    p_status_ser_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && !halted && op_code == OPC_RIM) |=> (rim_status[ST_W-1] == $past(ser_in)));

endmodule

// File: tb/mctl_irq_unit_bench.sv
`timescale 1ns/1ps
module mctl_irq_unit_bench;

    typedef struct {
        string      tag;
        logic [3:0] ts;
        logic [7:0] rim;
        logic       sod;
        logic       hlt;
        logic       ireq;
        logic [3:0] sel;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       op_valid = 1'b0;
    logic [7:0] op_code = 8'h00;
    logic [7:0] acc_in = 8'h00;
    logic       ser_in = 1'b0;
    logic [2:0] irq_req = 3'b000;
    logic       trap_req = 1'b0;
    logic       intr_ack = 1'b0;
    logic [3:0] t_states;
    logic [7:0] rim_status;
    logic       ser_out;
    logic       halted;
    logic       int_req;
    logic [3:0] int_sel;

    exp_t q[$];
    int   vectors = 0;
    int   miscompares = 0;
    bit   done = 1'b0;

    // reference state kept from the requirements
    logic       m_ie = 1'b0;
    logic [2:0] m_mask = 3'b111;
    logic       m_sod = 1'b0;
    logic       m_hlt = 1'b0;
    logic [3:0] m_ts = 4'd0;
    logic [7:0] m_rim = 8'h00;

    always #10 clk = ~clk;

    mctl_irq_unit u_mctl_irq_unit (
        .clk        (clk),
        .rst_n      (rst_n),
        .op_valid   (op_valid),
        .op_code    (op_code),
        .acc_in     (acc_in),
        .ser_in     (ser_in),
        .irq_req    (irq_req),
        .trap_req   (trap_req),
        .intr_ack   (intr_ack),
        .t_states   (t_states),
        .rim_status (rim_status),
        .ser_out    (ser_out),
        .halted     (halted),
        .int_req    (int_req),
        .int_sel    (int_sel)
    );

    function automatic logic [3:0] pick(input logic ie, input logic [2:0] mk,
                                        input logic [2:0] irq, input logic trap);
        logic [2:0] live;
        pick = 4'b0000;
        live = irq & ~mk & {3{ie}};
        if (trap) pick = 4'b1000;
        else if (live[2]) pick = 4'b0100;
        else if (live[1]) pick = 4'b0010;
        else if (live[0]) pick = 4'b0001;
    endfunction

    // driver: one cycle of stimulus, reference update, expected item pushed
    task automatic step(input bit v, input logic [7:0] op, input logic [7:0] acc,
                        input logic [2:0] irq, input bit trap, input bit ack,
                        input bit sin, input string tag);
        logic fwd_pre;
        logic taken;
        exp_t e;
        @(negedge clk);
        op_valid = v; op_code = op; acc_in = acc; irq_req = irq;
        trap_req = trap; intr_ack = ack; ser_in = sin;
        fwd_pre = (pick(m_ie, m_mask, irq, trap) != 4'b0000);
        taken = v && !m_hlt;
        if (taken) begin
            case (op)
                8'h00, 8'hF3, 8'hFB, 8'h30, 8'h20: m_ts = 4'd4;
                8'h76: m_ts = 4'd5;
                default: m_ts = 4'd0;
            endcase
            if (op == 8'h20) m_rim = {sin, irq, m_ie, m_mask};
            if (op == 8'h30 && acc[3]) m_mask = acc[2:0];
            if (op == 8'h30 && acc[6]) m_sod = acc[7];
            if (op == 8'hFB) m_ie = 1'b1;
            if (op == 8'hF3) m_ie = 1'b0;
        end
        if (ack) m_ie = 1'b0;
        if (m_hlt) m_hlt = !fwd_pre;
        else if (taken && op == 8'h76) m_hlt = 1'b1;
        @(posedge clk);
        #1;
        e.tag = tag; e.ts = m_ts; e.rim = m_rim; e.sod = m_sod; e.hlt = m_hlt;
        e.sel = pick(m_ie, m_mask, irq, trap);
        e.ireq = (e.sel != 4'b0000);
        q.push_back(e);
    endtask

    task automatic idle(input logic [2:0] irq, input bit trap, input string tag);
        step(1'b0, 8'h00, 8'h00, irq, trap, 1'b0, 1'b0, tag);
    endtask

    task automatic op(input logic [7:0] code, input logic [7:0] acc, input string tag);
        step(1'b1, code, acc, 3'b000, 1'b0, 1'b0, 1'b0, tag);
    endtask

    // monitor: compare outputs against queued expectations
    initial begin
        exp_t e;
        forever begin
            @(posedge clk);
            #5;
            while (q.size() > 0) begin
                e = q.pop_front();
                vectors++;
                if (t_states !== e.ts || rim_status !== e.rim || ser_out !== e.sod ||
                    halted !== e.hlt || int_req !== e.ireq || int_sel !== e.sel) begin
                    miscompares++;
                    $display("FAIL %s act ts=%0d rim=%h sod=%b hlt=%b ireq=%b sel=%b exp ts=%0d rim=%h sod=%b hlt=%b ireq=%b sel=%b",
                             e.tag, t_states, rim_status, ser_out, halted, int_req, int_sel,
                             e.ts, e.rim, e.sod, e.hlt, e.ireq, e.sel);
                end
            end
        end
    end

    // watchdog
    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            miscompares++;
            $display("FAIL R11 watchdog act=running exp=finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1: reset values, lines raised but enable flag clear
        idle(3'b111, 1'b0, "R1 reset state");
        op(8'h20, 8'h00, "R1 mask after reset via read");
        // R2: state counts
        op(8'h00, 8'h00, "R2 nop count");
        op(8'h55, 8'h00, "R2 unknown byte count");
        op(8'hF3, 8'h00, "R2 disable count");
        // R4: enable / disable via status
        op(8'hFB, 8'h00, "R4 enable count");
        op(8'h20, 8'h00, "R4 flag set in status");
        op(8'hF3, 8'h00, "R4 disable");
        op(8'h20, 8'h00, "R4 flag clear in status");
        // R6: mask write gated by field
        op(8'h30, 8'h0D, "R6 mask write 101");
        op(8'h20, 8'h00, "R6 status shows 101");
        op(8'h30, 8'h02, "R6 mask write without enable");
        op(8'h20, 8'h00, "R6 status keeps 101");
        // R3: no-op leaves state
        op(8'h00, 8'h00, "R3 nop");
        op(8'h20, 8'h00, "R3 status unchanged");
        op(8'h55, 8'h00, "R2 unknown byte");
        op(8'h20, 8'h00, "R2 unknown byte left state");
        // R7: serial output
        op(8'h30, 8'hC0, "R7 serial set");
        op(8'h30, 8'h80, "R7 serial write without enable");
        op(8'h30, 8'h40, "R7 serial clear");
        // R8: status layout with serial input and lines
        step(1'b1, 8'h20, 8'h00, 3'b101, 1'b0, 1'b0, 1'b1, "R8 status layout");
        // R9: forwarding and priority
        op(8'hFB, 8'h00, "R9 enable");
        op(8'h30, 8'h08, "R9 mask 000");
        idle(3'b011, 1'b0, "R9 line1 over line0");
        idle(3'b111, 1'b0, "R9 line2 highest");
        idle(3'b001, 1'b0, "R9 line0 alone");
        op(8'h30, 8'h0C, "R9 mask 100");
        idle(3'b100, 1'b0, "R9 masked line2 blocked");
        idle(3'b110, 1'b0, "R9 line1 passes mask");
        op(8'hF3, 8'h00, "R9 disable");
        idle(3'b111, 1'b0, "R9 flag clear blocks all");
        // R10: trap
        idle(3'b000, 1'b1, "R10 trap with flag clear");
        op(8'hFB, 8'h00, "R10 enable");
        idle(3'b111, 1'b1, "R10 trap over lines");
        // R5: acknowledge
        step(1'b0, 8'h00, 8'h00, 3'b010, 1'b0, 1'b1, 1'b0, "R5 ack clears flag");
        idle(3'b010, 1'b0, "R5 line blocked after ack");
        step(1'b1, 8'hFB, 8'h00, 3'b000, 1'b0, 1'b1, 1'b0, "R5 ack beats enable");
        op(8'h20, 8'h00, "R5 status flag clear");
        // R11: halt, ignore, wake by trap
        op(8'h76, 8'h00, "R11 halt count and flag");
        op(8'h30, 8'h0F, "R11 mask write ignored while halted");
        op(8'h20, 8'h00, "R11 read ignored while halted");
        idle(3'b111, 1'b0, "R11 blocked lines do not wake");
        idle(3'b000, 1'b1, "R11 trap wakes");
        op(8'h20, 8'h00, "R11 mask kept after wake");
        // R11: wake by maskable line
        op(8'hFB, 8'h00, "R11 enable");
        op(8'h30, 8'h08, "R11 mask 000");
        op(8'h76, 8'h00, "R11 halt again");
        idle(3'b000, 1'b0, "R11 stays halted");
        idle(3'b001, 1'b0, "R11 line0 wakes");
        op(8'h00, 8'h00, "R11 runs after wake");
        idle(3'b000, 1'b0, "drain");
        @(posedge clk);
        #8;
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule